// File: doc/BRIEF.md
# Three-Gain Sample Range Selector

This block sits behind three 10-bit converters that digitize one shaped analog pulse at three different gains. Between them the converters span a 15-bit dynamic range, but each alone only gives 10 bits. On every sample strobe the block looks at the three samples together. It keeps the one from the most sensitive converter that has not clipped. It then emits a single 12-bit word: a 2-bit range code on top and the chosen 10-bit sample below it.

Later stages, such as a delay pipeline or a peak finder, work on this coded word. They use the range code to know which gain the sample was taken at. A channel counts as clipped when its sample is at or above a threshold applied on an input port. In normal use that port is tied to 1023, full scale. Samples arrive at the converter rate, for example about 20.8 MHz. The result is registered, so it appears one clock after the strobe.

Top module: `adc_range_merge`

## Requirements
- R1: While reset is asserted and after its release, before the first strobe, `out_valid` is 0 and `out_word` is 0.
- R2: When the high-gain sample is below `sat_level`, the output is range code 00 (bits 11:10) with the high-gain sample in bits 9:0.
- R3: When the high-gain sample is saturated and the mid-gain sample is not, the output is code 01 with the mid-gain sample.
- R4: When the high-gain and mid-gain samples are saturated and the low-gain sample is not, the output is code 10 with the low-gain sample.
- R5: When all three samples are saturated, the output is code 10 with the data field clamped to 1023, whatever the low-gain value is.
- R6: A sample counts as saturated when it is greater than or equal to `sat_level`. A sample of `sat_level - 1` is not saturated. With `sat_level` = 0 every sample is saturated.
- R7: A sample presented with `in_valid` high appears on `out_word` after exactly one rising clock edge, and `out_valid` is `in_valid` delayed by one clock.
- R8: A clock with `in_valid` low leaves `out_word` unchanged and drives `out_valid` low, whatever the sample inputs hold.
- R9: Range code 11 never appears on `out_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a new sample triple |
| hi_sample | input | 10 | Sample from the high-gain converter |
| mid_sample | input | 10 | Sample from the mid-gain converter |
| lo_sample | input | 10 | Sample from the low-gain converter |
| sat_level | input | 10 | Saturation threshold; a sample at or above it is treated as clipped |
| out_valid | output | 1 | Coded word valid, one clock after `in_valid` |
| out_word | output | 12 | Range code in bits 11:10, chosen sample in bits 9:0 |

## Verification
The bench places samples exactly at the threshold and one count below it. A comparator built with strict greater-than would keep a clipped high-gain sample and report code 00 at full scale. The all-saturated case uses a low-gain value below full scale, so a design that forgets the clamp would pass that raw value through. It also sets the threshold to zero, where a wrong fall-through path would end on code 11. Idle clocks with moving inputs check that the word holds, and a mid-run reset checks that the word is cleared, so a design that ignores the strobe or the reset changes the output.

// File: rtl/adc_range_merge.sv
module adc_range_merge #(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [SAMPLE_W-1:0]          hi_sample,
  input  logic [SAMPLE_W-1:0]          mid_sample,
  input  logic [SAMPLE_W-1:0]          lo_sample,
  input  logic [SAMPLE_W-1:0]          sat_level,
  output logic                         out_valid,
  output logic [CODE_W+SAMPLE_W-1:0]   out_word
);

  localparam int WORD_W = CODE_W + SAMPLE_W;
  localparam logic [CODE_W-1:0]   CODE_HI  = CODE_W'(0);
  localparam logic [CODE_W-1:0]   CODE_MID = CODE_W'(1);
  localparam logic [CODE_W-1:0]   CODE_LO  = CODE_W'(2);
  localparam logic [SAMPLE_W-1:0] FULL     = '1;

  logic hi_sat, mid_sat, lo_sat;
  logic [CODE_W-1:0]   pick_code;
  logic [SAMPLE_W-1:0] pick_data;

  assign hi_sat  = hi_sample  >= sat_level;
  assign mid_sat = mid_sample >= sat_level;
  assign lo_sat  = lo_sample  >= sat_level;

  always_comb begin
    if (!hi_sat) begin
      pick_code = CODE_HI;
      pick_data = hi_sample;
    end else if (!mid_sat) begin
      pick_code = CODE_MID;
      pick_data = mid_sample;
    end else begin
      pick_code = CODE_LO;
      pick_data = lo_sat ? FULL : lo_sample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= {pick_code, pick_data};
    end
  end

  p_vld_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_vld_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word)));
  p_hi_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hi_sample < sat_level) |=>
      out_word == {CODE_HI, $past(hi_sample)});
  p_mid_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hi_sample >= sat_level && mid_sample < sat_level) |=>
      out_word == {CODE_MID, $past(mid_sample)});
  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hi_sample >= sat_level && mid_sample >= sat_level &&
     lo_sample >= sat_level) |=> out_word == {CODE_LO, FULL});
  p_no_code3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[WORD_W-1 -: CODE_W] != CODE_W'(3));

endmodule

// File: tb/test_adc_range_merge.sv
module test_adc_range_merge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [9:0] hi_sample = '0, mid_sample = '0, lo_sample = '0, sat_level = 10'd1023;
  logic out_valid;
  logic [11:0] out_word;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_range_merge i_adc_range_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .hi_sample(hi_sample), .mid_sample(mid_sample), .lo_sample(lo_sample),
    .sat_level(sat_level), .out_valid(out_valid), .out_word(out_word));

  // {hi, mid, lo, threshold, expected word}
  localparam int NV = 11;
  localparam logic [51:0] VEC [NV] = '{
    {10'd5,    10'd0,    10'd0,    10'd1023, 12'h005}, // R2
    {10'd1022, 10'd9,    10'd9,    10'd1023, 12'h3FE}, // R2 R6
    {10'd1023, 10'd200,  10'd4,    10'd1023, 12'h4C8}, // R3 R6
    {10'd1023, 10'd1023, 10'd77,   10'd1023, 12'h84D}, // R4
    {10'd1023, 10'd1023, 10'd1023, 10'd1023, 12'hBFF}, // R5
    {10'd512,  10'd511,  10'd3,    10'd512,  12'h5FF}, // R6 R3
    {10'd511,  10'd900,  10'd900,  10'd512,  12'h1FF}, // R6 R2
    {10'd600,  10'd700,  10'd300,  10'd512,  12'h92C}, // R4
    {10'd600,  10'd700,  10'd900,  10'd512,  12'hBFF}, // R5 clamp
    {10'd0,    10'd0,    10'd0,    10'd0,    12'hBFF}, // R6 zero threshold
    {10'd99,   10'd1023, 10'd1023, 10'd100,  12'h063}  // R2
  };

  task automatic chk(string req, logic v, logic [11:0] w, logic ev, logic [11:0] ew);
    total++;
    if (v !== ev || w !== ew) begin
      bad++;
      $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h", req, v, w, ev, ew);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", out_valid, out_word, 1'b0, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", out_valid, out_word, 1'b0, 12'h000);

    for (int i = 0; i < NV; i++) begin
      {hi_sample, mid_sample, lo_sample, sat_level} = VEC[i][51:12];
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R7 vector %0d", i), out_valid, out_word, 1'b1, VEC[i][11:0]);
      if (out_word[11:10] == 2'b11) chk("R9", 1'b1, out_word, 1'b1, 12'h000);
    end

    // R8: idle clocks with moving inputs keep the last word
    in_valid = 1'b0;
    hi_sample = 10'd3; mid_sample = 10'd4; lo_sample = 10'd5; sat_level = 10'd1023;
    @(negedge clk);
    chk("R8 idle 1", out_valid, out_word, 1'b0, 12'h063);
    hi_sample = 10'd1023;
    @(negedge clk);
    chk("R8 idle 2", out_valid, out_word, 1'b0, 12'h063);

    // R7: strobe after idle takes effect one edge later
    in_valid = 1'b1; hi_sample = 10'd1023; mid_sample = 10'd1023; lo_sample = 10'd1;
    @(negedge clk);
    chk("R7 R4 after idle", out_valid, out_word, 1'b1, 12'h801);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 valid drop", out_valid, out_word, 1'b0, 12'h801);

    // R1: mid-run reset clears the word
    in_valid = 1'b1; hi_sample = 10'd7;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", out_valid, out_word, 1'b0, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 after reset", out_valid, out_word, 1'b1, 12'h007);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule